// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading two levels of translation tables out of memory. A requester presents an address with a read/write direction. The walker then fetches a directory word from a table whose physical base comes from a base input. When that word is valid, it fetches a leaf word from the second-level table the directory word points at. It answers with the physical address and the 4-bit authority index carried in the leaf, or it answers with a fault.

The walker serves one request at a time. It keeps its ready output low while a walk is in flight. When translation is switched off, the address is returned unchanged one cycle after acceptance and memory is not touched. A walk that stops on an invalid directory word records a level-1 fault: it latches the faulting address and raises a level-1 status flag. A walk that stops on an invalid leaf word does the same for level 2. Result caching, permission enforcement and the memory fabric belong to neighbouring blocks.

Top module: `tw_walker`

## Requirements
- R1: After reset, req_ready is 1, while rsp_valid, mem_req_valid, l1_flag and l2_flag are 0 and both error-address outputs are 0.
- R2: With xlat_en = 0, an accepted request gives rsp_valid exactly one cycle later with rsp_paddr equal to the request address, rsp_aci = 0 and rsp_fault = 0, and no memory read is issued.
- R3: With xlat_en = 1, the first memory read of a walk goes to tbl_base + 4 * addr[31:20], and each read is a single-cycle pulse on mem_req_valid.
- R4: A directory word is valid only when its bits 1:0 are 01. Its bits 9:2 have no effect. When it is valid, the second read goes to {word[31:10], 10'b0} + 4 * addr[19:12].
- R5: A leaf word is valid when bit 1 is 1. Its bits 11:8, 3:2 and 0 have no effect. A valid leaf gives rsp_fault = 0, rsp_paddr = {leaf[31:12], addr[11:0]} and rsp_aci = leaf[7:4].
- R6: An invalid directory word ends the walk after one read. The response has rsp_fault = 1 and rsp_fault_l2 = 0, l1_flag becomes 1, and l1_err_addr holds the request address.
- R7: An invalid leaf word ends the walk after two reads. The response has rsp_fault = 1 and rsp_fault_l2 = 1, l2_flag becomes 1, and l2_err_addr holds the request address.
- R8: req_ready is 0 from the cycle after acceptance through the response cycle. rsp_valid lasts one cycle, and req_ready returns to 1 in the cycle after the response.
- R9: Both status flags clear when the next request is accepted. Each error address keeps its value until a later fault of the same level.
- R10: rsp_write returns the direction bit of the request that is being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlat_en | input | 1 | Global translation enable |
| tbl_base | input | 32 | Physical base of the directory table |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Direction of the request, 1 = write |
| req_ready | output | 1 | Walker idle and able to accept |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_aci | output | 4 | Authority index from the leaf word |
| rsp_write | output | 1 | Direction of the answered request |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_l2 | output | 1 | Fault was at level 2 (0 = level 1) |
| mem_req_valid | output | 1 | Memory read strobe |
| mem_req_addr | output | 32 | Memory read word address |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_data | input | 32 | Memory read data |
| l1_flag | output | 1 | Level-1 invalid status |
| l2_flag | output | 1 | Level-2 invalid status |
| l1_err_addr | output | 32 | Address of the last level-1 fault |
| l2_err_addr | output | 32 | Address of the last level-2 fault |

## Verification
A wrong walk state shows at the memory port first. A missing, doubled or misplaced read address appears on the cycle after acceptance, or on the cycle after the directory word returns, well before any response. A corrupted captured table pointer or request address shows as a wrong physical address or authority index in the single response cycle. A mis-tracked fault level shows as the wrong flag or the wrong error-address register in that same cycle. A stuck state shows as req_ready failing to return to 1 one cycle after the response.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_WT_DIR,
        ST_RD_LEAF,
        ST_WT_LEAF,
        ST_DONE,
        ST_FAULT
    } walk_st_e;
endpackage

// File: rtl/tw_entry_decode.sv
module tw_entry_decode #(
    parameter int AW        = 32,
    parameter int TBL_BITS  = 8,
    parameter int PAGE_BITS = 12,
    parameter int ACI_W     = 4,
    parameter int ACI_LSB   = 4
) (
    input  logic [AW-1:0]           word,
    output logic                    dir_ok,
    output logic [AW-1:0]           tbl_addr,
    output logic                    leaf_ok,
    output logic [AW-PAGE_BITS-1:0] frame,
    output logic [ACI_W-1:0]        aci
);
    localparam int TBL_ALIGN = TBL_BITS + 2;

    logic unused_word_bits;

    always_comb begin
        dir_ok   = (word[1:0] == 2'b01);
        tbl_addr = {word[AW-1:TBL_ALIGN], {TBL_ALIGN{1'b0}}};
        leaf_ok  = word[1];
        frame    = word[AW-1:PAGE_BITS];
        aci      = word[ACI_LSB +: ACI_W];
    end

    assign unused_word_bits = ^word;
endmodule

// File: rtl/tw_fault_log.sv
module tw_fault_log #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set_l1,
    input  logic          set_l2,
    input  logic [AW-1:0] addr,
    output logic          l1_flag,
    output logic          l2_flag,
    output logic [AW-1:0] l1_err_addr,
    output logic [AW-1:0] l2_err_addr
);
    typedef struct packed {
        logic          f1;
        logic          f2;
        logic [AW-1:0] a1;
        logic [AW-1:0] a2;
    } log_t;

    log_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d.f1 = 1'b0;
            d.f2 = 1'b0;
        end
        if (set_l1) begin
            d.f1 = 1'b1;
            d.a1 = addr;
        end
        if (set_l2) begin
            d.f2 = 1'b1;
            d.a2 = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign l1_flag     = q.f1;
    assign l2_flag     = q.f2;
    assign l1_err_addr = q.a1;
    assign l2_err_addr = q.a2;

    // R6: a level-1 hit leaves the flag up and the address captured
    a_r6_l1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        set_l1 |=> (l1_flag && l1_err_addr == $past(addr)));
    // R7: same for level 2
    a_r7_l2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        set_l2 |=> (l2_flag && l2_err_addr == $past(addr)));
    // R9: acceptance of a new request drops both flags
    a_r9_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_l1 && !set_l2) |=> (!l1_flag && !l2_flag));
    // R9: error address only moves on a fault of its own level
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !set_l1 |=> $stable(l1_err_addr));
endmodule

// File: rtl/tw_walk_fsm.sv
module tw_walk_fsm
    import tw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DIR_BITS  = 12,
    parameter int TBL_BITS  = 8,
    parameter int PAGE_BITS = 12,
    parameter int ACI_W     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xlat_en,
    input  logic [AW-1:0]           tbl_base,
    input  logic                    req_valid,
    input  logic [AW-1:0]           req_addr,
    input  logic                    req_write,
    output logic                    req_ready,
    output logic                    rsp_valid,
    output logic [AW-1:0]           rsp_paddr,
    output logic [ACI_W-1:0]        rsp_aci,
    output logic                    rsp_write,
    output logic                    rsp_fault,
    output logic                    rsp_fault_l2,
    output logic                    mem_req_valid,
    output logic [AW-1:0]           mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic                    dir_ok,
    input  logic [AW-1:0]           tbl_addr,
    input  logic                    leaf_ok,
    input  logic [AW-PAGE_BITS-1:0] frame,
    input  logic [ACI_W-1:0]        aci,
    output logic                    accept,
    output logic                    hit_l1,
    output logic                    hit_l2,
    output logic [AW-1:0]           fault_va
);
    localparam int DIR_LSB  = PAGE_BITS + TBL_BITS;
    localparam int DIR_PAD  = AW - DIR_BITS - 2;
    localparam int TBL_PAD  = AW - TBL_BITS - 2;

    typedef struct packed {
        walk_st_e         st;
        logic [AW-1:0]    va;
        logic             wr;
        logic [AW-1:0]    tbl;
        logic [AW-1:0]    pa;
        logic [ACI_W-1:0] aci;
        logic             fault;
        logic             lvl2;
    } walk_t;

    walk_t d, q;

    logic [DIR_BITS-1:0] dir_idx;
    logic [TBL_BITS-1:0] leaf_idx;

    assign dir_idx  = q.va[DIR_LSB +: DIR_BITS];
    assign leaf_idx = q.va[PAGE_BITS +: TBL_BITS];

    always_comb begin
        d      = q;
        accept = 1'b0;
        hit_l1 = 1'b0;
        hit_l2 = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    d.va    = req_addr;
                    d.wr    = req_write;
                    d.fault = 1'b0;
                    d.lvl2  = 1'b0;
                    d.aci   = '0;
                    d.pa    = req_addr;
                    d.st    = xlat_en ? ST_RD_DIR : ST_DONE;
                end
            end
            ST_RD_DIR:  d.st = ST_WT_DIR;
            ST_WT_DIR: begin
                if (mem_rsp_valid) begin
                    if (dir_ok) begin
                        d.tbl = tbl_addr;
                        d.st  = ST_RD_LEAF;
                    end else begin
                        hit_l1  = 1'b1;
                        d.fault = 1'b1;
                        d.pa    = '0;
                        d.st    = ST_FAULT;
                    end
                end
            end
            ST_RD_LEAF: d.st = ST_WT_LEAF;
            ST_WT_LEAF: begin
                if (mem_rsp_valid) begin
                    if (leaf_ok) begin
                        d.pa  = {frame, q.va[PAGE_BITS-1:0]};
                        d.aci = aci;
                        d.st  = ST_DONE;
                    end else begin
                        hit_l2  = 1'b1;
                        d.fault = 1'b1;
                        d.lvl2  = 1'b1;
                        d.pa    = '0;
                        d.st    = ST_FAULT;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        mem_req_valid = (q.st == ST_RD_DIR) || (q.st == ST_RD_LEAF);
        if (q.st == ST_RD_LEAF)
            mem_req_addr = q.tbl + {{TBL_PAD{1'b0}}, leaf_idx, 2'b00};
        else
            mem_req_addr = tbl_base + {{DIR_PAD{1'b0}}, dir_idx, 2'b00};
    end

    assign req_ready    = (q.st == ST_IDLE);
    assign rsp_valid    = (q.st == ST_DONE) || (q.st == ST_FAULT);
    assign rsp_paddr    = q.pa;
    assign rsp_aci      = q.aci;
    assign rsp_write    = q.wr;
    assign rsp_fault    = q.fault;
    assign rsp_fault_l2 = q.lvl2;
    assign fault_va     = q.va;

    // R8: busy right after acceptance
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R8: response is a single-cycle strobe followed by idle
    a_r8_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
    // R2: bypass answers next cycle without touching memory
    a_r2_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_en) |=> (rsp_valid && !mem_req_valid));
    // R3: memory reads are single pulses
    a_r3_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    // R5: successful results keep the page offset of the request
    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_BITS-1:0] == fault_va[PAGE_BITS-1:0]));
endmodule

// File: rtl/tw_walker.sv
module tw_walker #(
    parameter int AW        = 32,
    parameter int DIR_BITS  = 12,
    parameter int TBL_BITS  = 8,
    parameter int PAGE_BITS = 12,
    parameter int ACI_W     = 4,
    parameter int ACI_LSB   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlat_en,
    input  logic [AW-1:0]    tbl_base,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [AW-1:0]    rsp_paddr,
    output logic [ACI_W-1:0] rsp_aci,
    output logic             rsp_write,
    output logic             rsp_fault,
    output logic             rsp_fault_l2,
    output logic             mem_req_valid,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [AW-1:0]    mem_rsp_data,
    output logic             l1_flag,
    output logic             l2_flag,
    output logic [AW-1:0]    l1_err_addr,
    output logic [AW-1:0]    l2_err_addr
);
    localparam int FRAME_W = AW - PAGE_BITS;

    logic               dir_ok, leaf_ok;
    logic [AW-1:0]      tbl_addr;
    logic [FRAME_W-1:0] frame;
    logic [ACI_W-1:0]   aci;
    logic               accept, hit_l1, hit_l2;
    logic [AW-1:0]      fault_va;

    tw_entry_decode #(
        .AW(AW), .TBL_BITS(TBL_BITS), .PAGE_BITS(PAGE_BITS),
        .ACI_W(ACI_W), .ACI_LSB(ACI_LSB)
    ) u_dec (
        .word(mem_rsp_data), .dir_ok(dir_ok), .tbl_addr(tbl_addr),
        .leaf_ok(leaf_ok), .frame(frame), .aci(aci)
    );

    tw_walk_fsm #(
        .AW(AW), .DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS),
        .PAGE_BITS(PAGE_BITS), .ACI_W(ACI_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_aci(rsp_aci), .rsp_write(rsp_write), .rsp_fault(rsp_fault),
        .rsp_fault_l2(rsp_fault_l2), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .dir_ok(dir_ok), .tbl_addr(tbl_addr), .leaf_ok(leaf_ok),
        .frame(frame), .aci(aci), .accept(accept), .hit_l1(hit_l1),
        .hit_l2(hit_l2), .fault_va(fault_va)
    );

    tw_fault_log #(.AW(AW)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(accept), .set_l1(hit_l1),
        .set_l2(hit_l2), .addr(fault_va), .l1_flag(l1_flag),
        .l2_flag(l2_flag), .l1_err_addr(l1_err_addr), .l2_err_addr(l2_err_addr)
    );

    // R6: a level-1 fault response comes with the level-1 flag raised
    a_r6_flag_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_fault_l2) |-> (l1_flag && !l2_flag));
    // R7: a level-2 fault response comes with the level-2 flag raised
    a_r7_flag_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_fault_l2) |-> (l2_flag && !l1_flag));
endmodule

// File: tb/sim_tw_walker.sv
module sim_tw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_ready, rsp_valid, rsp_write, rsp_fault, rsp_fault_l2;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_aci;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        l1_flag, l2_flag;
    logic [31:0] l1_err_addr, l2_err_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    tw_walker u0 (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_aci(rsp_aci), .rsp_write(rsp_write), .rsp_fault(rsp_fault),
        .rsp_fault_l2(rsp_fault_l2), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .l1_flag(l1_flag), .l2_flag(l2_flag),
        .l1_err_addr(l1_err_addr), .l2_err_addr(l2_err_addr)
    );

    // memory model: sparse word store, fixed latency
    localparam int LAT = 3;
    logic [31:0] mem [logic [31:0]];
    int          pend = 0;
    logic [31:0] pend_addr = '0;
    int          rd_count = 0;
    logic [31:0] rd_log [2];

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid) begin
            pend      <= LAT;
            pend_addr <= mem_req_addr;
            if (rd_count < 2) rd_log[rd_count] <= mem_req_addr;
            rd_count  <= rd_count + 1;
        end else if (pend > 1) begin
            pend <= pend - 1;
        end else if (pend == 1) begin
            pend          <= 0;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) timed_out <= 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // walk vectors: va, write, fault kind (0 ok,1 lvl1,2 lvl2), pa, aci, reads, rd0, rd1
    localparam int NV = 7;
    localparam logic [31:0] V_VA  [NV] = '{32'h0013_4ABC, 32'h0013_5001, 32'h001F_F7FF,
                                           32'h0013_6000, 32'hFFF0_0123, 32'h0020_0010, 32'h0040_0000};
    localparam logic        V_WR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam int          V_FK  [NV] = '{0, 0, 0, 2, 0, 1, 1};
    localparam logic [31:0] V_PA  [NV] = '{32'hABCD_EABC, 32'h1234_5001, 32'hFFFF_F7FF,
                                           32'h0, 32'h0004_2123, 32'h0, 32'h0};
    localparam logic [3:0]  V_ACI [NV] = '{4'h5, 4'h4, 4'hF, 4'h0, 4'h1, 4'h0, 4'h0};
    localparam logic [31:0] V_RD0 [NV] = '{32'h0010_0004, 32'h0010_0004, 32'h0010_0004,
                                           32'h0010_0004, 32'h0010_3FFC, 32'h0010_0008, 32'h0010_0010};
    localparam logic [31:0] V_RD1 [NV] = '{32'h0020_00D0, 32'h0020_00D4, 32'h0020_03FC,
                                           32'h0020_00D8, 32'h0030_0C00, 32'h0, 32'h0};

    int lat_cycles;

    task automatic issue(input logic [31:0] va, input logic wr);
        @(negedge clk);
        while (!req_ready && !timed_out) @(negedge clk);
        rd_count  = 0;
        req_valid = 1'b1;
        req_addr  = va;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        lat_cycles = 1;
        while (!rsp_valid && !timed_out) begin
            @(negedge clk);
            lat_cycles++;
        end
    endtask

    initial begin
        mem[32'h0010_0004] = 32'h0020_03FD;  // valid, bits 9:2 all ones
        mem[32'h0020_00D0] = 32'hABCD_EF5F;  // valid leaf, ignored bits set
        mem[32'h0020_00D4] = 32'h1234_5042;
        mem[32'h0020_03FC] = 32'hFFFF_F0F2;
        mem[32'h0020_00D8] = 32'h5555_5051;  // bit 1 clear: invalid leaf
        mem[32'h0010_3FFC] = 32'h0030_0C01;
        mem[32'h0030_0C00] = 32'h0004_2012;
        mem[32'h0010_0008] = 32'h0040_0003;  // bits 1:0 = 11: invalid
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req_valid}, 32'd0);
        chk("R1 flags", {30'b0, l1_flag, l2_flag}, 32'd0);
        chk("R1 l1_err", l1_err_addr, 32'd0);
        chk("R1 l2_err", l2_err_addr, 32'd0);
        rst_n = 1'b1;

        // R2 bypass
        issue(32'h89AB_CDEF, 1'b1);
        chk("R2 latency", lat_cycles, 32'd1);
        chk("R2 paddr", rsp_paddr, 32'h89AB_CDEF);
        chk("R2 aci", {28'b0, rsp_aci}, 32'd0);
        chk("R2 fault", {31'b0, rsp_fault}, 32'd0);
        chk("R2 no reads", rd_count, 32'd0);
        chk("R10 write echo bypass", {31'b0, rsp_write}, 32'd1);
        @(negedge clk);
        chk("R8 ready after rsp", {31'b0, req_ready}, 32'd1);

        xlat_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            issue(V_VA[i], V_WR[i]);
            chk("R10 write echo", {31'b0, rsp_write}, {31'b0, V_WR[i]});
            chk("R3 dir read addr", rd_log[0], V_RD0[i]);
            if (V_FK[i] == 0) begin
                chk("R5 fault", {31'b0, rsp_fault}, 32'd0);
                chk("R5 paddr", rsp_paddr, V_PA[i]);
                chk("R5 aci", {28'b0, rsp_aci}, {28'b0, V_ACI[i]});
                chk("R4 leaf read addr", rd_log[1], V_RD1[i]);
                chk("R4 reads", rd_count, 32'd2);
                chk("R9 flags clear", {30'b0, l1_flag, l2_flag}, 32'd0);
            end else if (V_FK[i] == 1) begin
                chk("R6 fault", {30'b0, rsp_fault, rsp_fault_l2}, 32'b10);
                chk("R6 reads", rd_count, 32'd1);
                chk("R6 flag", {30'b0, l1_flag, l2_flag}, 32'b10);
                chk("R6 err addr", l1_err_addr, V_VA[i]);
            end else begin
                chk("R7 fault", {30'b0, rsp_fault, rsp_fault_l2}, 32'b11);
                chk("R7 reads", rd_count, 32'd2);
                chk("R4 leaf read addr", rd_log[1], V_RD1[i]);
                chk("R7 flag", {30'b0, l1_flag, l2_flag}, 32'b01);
                chk("R7 err addr", l2_err_addr, V_VA[i]);
            end
        end

        // R9: level-2 address kept across level-1 faults and good walks
        chk("R9 l2 addr held", l2_err_addr, 32'h0013_6000);
        issue(32'h0013_4000, 1'b0);
        chk("R9 l1 addr held", l1_err_addr, 32'h0040_0000);
        chk("R9 flags cleared", {30'b0, l1_flag, l2_flag}, 32'd0);

        // R8: ready stays low during a walk
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0013_5000; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy", {31'b0, req_ready}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R8 still busy", {31'b0, req_ready}, 32'd0);
        while (!rsp_valid && !timed_out) @(negedge clk);
        chk("R8 busy at rsp", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R8 single rsp", {31'b0, rsp_valid}, 32'd0);
        chk("R8 idle again", {31'b0, req_ready}, 32'd1);

        if (timed_out) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule